// File: doc/BRIEF.md
# UART Sticky Status and Interrupt Identification

This block holds the status state of a 16550-style UART as the register bus sees it. Error pulses from a receiver are latched into a line status register, and changes on the modem control inputs are latched as delta flags beside the live input levels. A transmit-holding-empty event is held as a pending flag. A priority encoder turns the enabled sources into an interrupt identification value and an interrupt request line.

Reading the line status or modem status register clears the sticky bits. Reading the identification register clears the transmit-empty flag, but only when that flag is the source the read reports. A clear only removes the bits that the read returned. An event that arrives in the same clock as the read is kept, so the next read returns it.

Software selects a register with `rd_sel` and qualifies the access with `rd_en`. Read data is combinational from the current state. The clearing takes effect at the clock edge that ends the read cycle. The serial shifter and the FIFOs are not part of the block: they are stood in for by input pulses and a data-ready level.

Top module: `uart_sticky_status`

## Requirements
- R1: After a synchronous active-low reset, all sticky bits, the enable register and the live modem levels are 0. The identification register reads 0x01 and `irq` is low.
- R2: The line status read (`rd_sel`=0) returns overrun in bit 0, parity error in bit 1, framing error in bit 2 and break in bit 3, with bits 7:4 at 0. Each bit is set by a one-cycle pulse on its input. A read clears the bits it returned.
- R3: The modem status read (`rd_sel`=1) returns delta CTS in bit 0, delta DSR in bit 1, trailing-edge RI in bit 2 and delta DCD in bit 3. It returns the live levels of CTS, DSR, RI and DCD in bits 4 to 7. A read clears the delta bits but not the levels.
- R4: A sticky bit whose set event occurs in the same cycle as a read of its register still holds after that read, and the next read returns it.
- R5: Any change on CTS, DSR or DCD sets the matching delta bit in the same clock that updates the live level. RI sets its bit only on a 1-to-0 transition; a rising RI sets nothing.
- R6: The identification read (`rd_sel`=2) returns bit 0 = 0 when any enabled source is pending, with the source code in bits 2:1. The codes are 3 = line status, 2 = received data available, 1 = transmit holding empty and 0 = modem status. The highest code that is pending wins. With nothing pending the read returns 0x01.
- R7: A `thr_empty_evt` pulse sets a transmit-empty flag. An identification read clears that flag only when it reports code 1. If a higher source is pending, the flag stays set and is reported later. The read has no effect on the line or modem bits.
- R8: The enable register (`rd_sel`=3 reads it back in bits 3:0) is written by `ier_wr`. Its bit 0 enables received data, bit 1 transmit empty, bit 2 line status and bit 3 modem status. A disabled source is absent from the identification value and from `irq`, but its sticky bits are still latched.
- R9: `irq` is high exactly when the identification register would read bit 0 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Register read strobe, one per cycle |
| rd_sel | input | 2 | 0 line status, 1 modem status, 2 identification, 3 enable |
| rd_data | output | 8 | Read data for the selected register |
| ier_wr | input | 1 | Write strobe for the enable register |
| ier_wdata | input | 4 | Enable register write data |
| rx_overrun | input | 1 | Overrun event pulse |
| rx_parity_err | input | 1 | Parity error event pulse |
| rx_frame_err | input | 1 | Framing error event pulse |
| rx_break | input | 1 | Break detected event pulse |
| rx_data_ready | input | 1 | Received data available level |
| thr_empty_evt | input | 1 | Transmit holding register became empty |
| cts | input | 1 | Clear-to-send level, already synchronised |
| dsr | input | 1 | Data-set-ready level, already synchronised |
| ri | input | 1 | Ring indicator level, already synchronised |
| dcd | input | 1 | Carrier detect level, already synchronised |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that the modem inputs are already synchronised to `clk` and change at most once per cycle. They also assume that event pulses last a single cycle and that `rd_en` marks at most one register read per cycle. The stimulus drives every input just after the falling edge and holds it for a full cycle. Error pulses are often placed in the same cycle as a read of their own register, and modem levels are toggled while a modem read is in progress. This exercises the read-set collision without breaking these assumptions.

// File: rtl/uart_stat_pkg.sv
// Shared constants for the UART sticky status block.
// Assumes an 8-bit register bus and four error and four modem lines.
package uart_stat_pkg;
    localparam int REG_W   = 8;
    localparam int N_ERR   = 4;
    localparam int N_MODEM = 4;
    localparam int N_SRC   = 4;
    localparam int ID_W    = $clog2(N_SRC);

    // Register select codes on the read bus
    localparam logic [1:0] SEL_LSR = 2'd0;
    localparam logic [1:0] SEL_MSR = 2'd1;
    localparam logic [1:0] SEL_IIR = 2'd2;
    localparam logic [1:0] SEL_IER = 2'd3;

    // Source codes; a larger code means a higher priority
    localparam logic [ID_W-1:0] SRC_MODEM  = 2'd0;
    localparam logic [ID_W-1:0] SRC_THRE   = 2'd1;
    localparam logic [ID_W-1:0] SRC_RXDATA = 2'd2;
    localparam logic [ID_W-1:0] SRC_LINE   = 2'd3;

    // Enable register bit positions
    localparam int EN_RXDATA = 0;
    localparam int EN_THRE   = 1;
    localparam int EN_LINE   = 2;
    localparam int EN_MODEM  = 3;

    // Position of the ring indicator within the modem line vector
    localparam int RI_IDX = 2;
endpackage

// File: rtl/uart_sticky_bank.sv
// Bank of independent sticky bits. Set has priority over clear, so an
// event that coincides with a clearing read survives the read.
// Assumes clr_i carries only the bits the read returned.
module uart_sticky_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Hold, set or clear one sticky bit
        always_ff @(posedge clk) begin
            if (!rst_n) q_o[i] <= 1'b0;
            else        q_o[i] <= set_i[i] | (q_o[i] & ~clr_i[i]);
        end
    end
endmodule

// File: rtl/uart_modem_track.sv
// Registers the live modem levels and flags each transition of interest.
// The ring indicator line flags only a falling edge; the others flag any change.
// Assumes the lines are already synchronised to clk.
module uart_modem_track #(
    parameter int N      = 4,
    parameter int RI_POS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] chg_o
);
    // Capture the current levels
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_o <= '0;
        else        lvl_o <= lines_i;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        if (i == RI_POS) begin : g_trail
            // Trailing edge only
            assign chg_o[i] = lvl_o[i] & ~lines_i[i];
        end else begin : g_any
            // Any transition
            assign chg_o[i] = lvl_o[i] ^ lines_i[i];
        end
    end
endmodule

// File: rtl/uart_irq_prio.sv
// Fixed-priority encoder: the highest-indexed active request wins.
// Assumes the request index equals the source code.
module uart_irq_prio #(
    parameter int NSRC = 4,
    parameter int IDW  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] req_i,
    output logic            pend_o,
    output logic [IDW-1:0]  id_o
);
    // Pick the winning source code
    always_comb begin
        id_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req_i[i]) id_o = IDW'(i);
        end
    end

    assign pend_o = |req_i;
endmodule

// File: rtl/uart_sticky_status.sv
// Status registers of a 16550-style UART: line errors, modem deltas,
// transmit-empty flag, enable register, identification and interrupt.
// Reads clear only the bits they returned. Events in the read cycle persist.
// Assumes at most one read per cycle and single-cycle event pulses.
module uart_sticky_status
    import uart_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [1:0]       rd_sel,
    output logic [REG_W-1:0] rd_data,
    input  logic             ier_wr,
    input  logic [N_SRC-1:0] ier_wdata,
    input  logic             rx_overrun,
    input  logic             rx_parity_err,
    input  logic             rx_frame_err,
    input  logic             rx_break,
    input  logic             rx_data_ready,
    input  logic             thr_empty_evt,
    input  logic             cts,
    input  logic             dsr,
    input  logic             ri,
    input  logic             dcd,
    output logic             irq
);
    logic [N_ERR-1:0]   err_set, lsr_clr, lsr_q;
    logic [N_MODEM-1:0] modem_in, live_lvl, modem_chg, msr_clr, msr_delta_q;
    logic [N_SRC-1:0]   ier_q, src_req;
    logic [ID_W-1:0]    src_id;
    logic               src_pend, thre_q, thre_clr;
    logic               rd_lsr, rd_msr, rd_iir;

    assign rd_lsr = rd_en && (rd_sel == SEL_LSR);
    assign rd_msr = rd_en && (rd_sel == SEL_MSR);
    assign rd_iir = rd_en && (rd_sel == SEL_IIR);

    assign err_set  = {rx_break, rx_frame_err, rx_parity_err, rx_overrun};
    assign modem_in = {dcd, ri, dsr, cts};

    // A read clears exactly the bits it returned
    assign lsr_clr  = rd_lsr ? lsr_q : '0;
    assign msr_clr  = rd_msr ? msr_delta_q : '0;
    assign thre_clr = rd_iir && src_pend && (src_id == SRC_THRE);

    uart_sticky_bank #(.W(N_ERR)) u_lsr_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (err_set),
        .clr_i (lsr_clr),
        .q_o   (lsr_q)
    );

    uart_modem_track #(.N(N_MODEM), .RI_POS(RI_IDX)) u_modem (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (modem_in),
        .lvl_o   (live_lvl),
        .chg_o   (modem_chg)
    );

    uart_sticky_bank #(.W(N_MODEM)) u_msr_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (modem_chg),
        .clr_i (msr_clr),
        .q_o   (msr_delta_q)
    );

    // Transmit-empty pending flag, set wins over a coincident clear
    always_ff @(posedge clk) begin
        if (!rst_n) thre_q <= 1'b0;
        else        thre_q <= thr_empty_evt | (thre_q & ~thre_clr);
    end

    // Interrupt enable register
    always_ff @(posedge clk) begin
        if (!rst_n)      ier_q <= '0;
        else if (ier_wr) ier_q <= ier_wdata;
    end

    // Gate each source class by its enable bit
    always_comb begin
        src_req             = '0;
        src_req[SRC_LINE]   = ier_q[EN_LINE]   & (|lsr_q);
        src_req[SRC_RXDATA] = ier_q[EN_RXDATA] & rx_data_ready;
        src_req[SRC_THRE]   = ier_q[EN_THRE]   & thre_q;
        src_req[SRC_MODEM]  = ier_q[EN_MODEM]  & (|msr_delta_q);
    end

    uart_irq_prio #(.NSRC(N_SRC), .IDW(ID_W)) u_prio (
        .req_i  (src_req),
        .pend_o (src_pend),
        .id_o   (src_id)
    );

    assign irq = src_pend;

    // Read data multiplexer
    always_comb begin
        case (rd_sel)
            SEL_LSR: rd_data = REG_W'(lsr_q);
            SEL_MSR: rd_data = REG_W'({live_lvl, msr_delta_q});
            SEL_IIR: rd_data = REG_W'({src_id, ~src_pend});
            default: rd_data = REG_W'(ier_q);
        endcase
    end
endmodule

// File: rtl/uart_stat_chk.sv
// Property checker for uart_sticky_status, attached with bind.
// Assumes single-cycle event pulses and synchronised modem inputs.
module uart_stat_chk
    import uart_stat_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic [1:0]       rd_sel,
    input logic [REG_W-1:0] rd_data,
    input logic [N_ERR-1:0] err_set,
    input logic [N_ERR-1:0] lsr_q,
    input logic [N_MODEM-1:0] msr_delta_q,
    input logic             cts,
    input logic             cts_live,
    input logic             thre_q,
    input logic [N_SRC-1:0] ier_q,
    input logic             irq
);
    // R2: a line status read without new events leaves no error bit set
    a_r2_lsr_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == SEL_LSR && err_set == '0) |=> (lsr_q == '0));

    // R4: parity set during a line status read survives
    a_r4_set_survives: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == SEL_LSR && err_set[1]) |=> lsr_q[1]);

    // R5: a CTS change raises delta CTS
    a_r5_cts_delta: assert property (@(posedge clk) disable iff (!rst_n)
        (cts != cts_live) |=> msr_delta_q[0]);

    // R7: transmit-empty flag kept when line status outranks it
    a_r7_thre_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == SEL_IIR && ier_q[EN_LINE] && (|lsr_q) && thre_q) |=> thre_q);

    // R8: nothing enabled means no request
    a_r8_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q == '0) |-> !irq);

    // R9: request line agrees with identification bit 0
    a_r9_irq_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == SEL_IIR) |-> (rd_data[0] == !irq));
endmodule

bind uart_sticky_status uart_stat_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .rd_sel      (rd_sel),
    .rd_data     (rd_data),
    .err_set     (err_set),
    .lsr_q       (lsr_q),
    .msr_delta_q (msr_delta_q),
    .cts         (cts),
    .cts_live    (live_lvl[0]),
    .thre_q      (thre_q),
    .ier_q       (ier_q),
    .irq         (irq)
);

// File: tb/uart_sticky_status_bench.sv
// Reference-model bench for uart_sticky_status: directed cases, then random traffic.
module uart_sticky_status_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;
    logic       ier_wr = 1'b0;
    logic [3:0] ier_wdata = 4'd0;
    logic       rx_overrun = 0, rx_parity_err = 0, rx_frame_err = 0, rx_break = 0;
    logic       rx_data_ready = 0, thr_empty_evt = 0;
    logic       cts = 0, dsr = 0, ri = 0, dcd = 0;
    logic       irq;

    always #10 clk = ~clk;

    uart_sticky_status u_uart_sticky_status (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .rx_overrun(rx_overrun), .rx_parity_err(rx_parity_err),
        .rx_frame_err(rx_frame_err), .rx_break(rx_break),
        .rx_data_ready(rx_data_ready), .thr_empty_evt(thr_empty_evt),
        .cts(cts), .dsr(dsr), .ri(ri), .dcd(dcd), .irq(irq)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Behavioural model state
    logic [3:0] m_lsr = 0, m_dlt = 0, m_ier = 0, m_lvl = 0;
    logic       m_thre = 0;
    logic [7:0] got_rd;

    function automatic logic [7:0] m_iir();
        if (m_ier[2] && m_lsr != 0)    return 8'h06;
        if (m_ier[0] && rx_data_ready) return 8'h04;
        if (m_ier[1] && m_thre)        return 8'h02;
        if (m_ier[3] && m_dlt != 0)    return 8'h00;
        return 8'h01;
    endfunction

    function automatic logic [7:0] m_read(input logic [1:0] s);
        case (s)
            2'd0:    return {4'h0, m_lsr};
            2'd1:    return {m_lvl, m_dlt};
            2'd2:    return m_iir();
            default: return {4'h0, m_ier};
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // One clock: compare before the edge, advance the model at the edge
    task automatic cycle();
        logic [3:0] ev, cur, nd, n_lsr, n_dlt, n_ier;
        logic       n_thre;
        #2;
        got_rd = rd_data;
        if (rd_en) begin
            case (rd_sel)
                2'd0:    chk("R2", rd_data, m_read(rd_sel));
                2'd1:    chk("R3", rd_data, m_read(rd_sel));
                2'd2:    chk("R6", rd_data, m_read(rd_sel));
                default: chk("R8", rd_data, m_read(rd_sel));
            endcase
        end
        chk("R9", {7'd0, irq}, {7'd0, ~m_iir()[0]});
        ev    = {rx_break, rx_frame_err, rx_parity_err, rx_overrun};
        cur   = {dcd, ri, dsr, cts};
        nd    = cur ^ m_lvl;
        nd[2] = m_lvl[2] & ~cur[2];
        n_lsr  = (rd_en && rd_sel == 2'd0) ? ev : (m_lsr | ev);
        n_dlt  = ((rd_en && rd_sel == 2'd1) ? 4'h0 : m_dlt) | nd;
        n_thre = (rd_en && rd_sel == 2'd2 && m_iir() == 8'h02) ? thr_empty_evt
                                                                : (m_thre | thr_empty_evt);
        n_ier  = ier_wr ? ier_wdata : m_ier;
        @(posedge clk);
        m_lsr = n_lsr; m_dlt = n_dlt; m_thre = n_thre; m_ier = n_ier; m_lvl = cur;
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] s);
        rd_en = 1; rd_sel = s;
        cycle();
        rd_en = 0;
    endtask

    task automatic wr_ier(input logic [3:0] v);
        ier_wr = 1; ier_wdata = v;
        cycle();
        ier_wr = 0;
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        rd(2'd2); chk("R1", got_rd, 8'h01);
        chk("R1", {7'd0, irq}, 8'h00);
        rd(2'd0); chk("R1", got_rd, 8'h00);
        rd(2'd1); chk("R1", got_rd, 8'h00);
        wr_ier(4'hF);

        // R2: parity bit and clear on read
        rx_parity_err = 1; cycle(); rx_parity_err = 0;
        rd(2'd0); chk("R2", got_rd, 8'h02);
        rd(2'd0); chk("R2", got_rd, 8'h00);

        // R4: framing error in the read cycle survives
        rx_overrun = 1; cycle(); rx_overrun = 0;
        rx_frame_err = 1; rd(2'd0); rx_frame_err = 0;
        chk("R4", got_rd, 8'h01);
        rd(2'd0); chk("R4", got_rd, 8'h04);

        // R5 / R3: CTS change, RI rising then falling
        cts = 1; cycle();
        rd(2'd1); chk("R3", got_rd, 8'h11);
        rd(2'd1); chk("R3", got_rd, 8'h10);
        ri = 1; cycle();
        rd(2'd1); chk("R5", got_rd, 8'h50);
        ri = 0; dcd = 1; cycle();
        rd(2'd1); chk("R5", got_rd, 8'h9C);

        // R4: DSR change during a modem read survives
        dsr = 1; rd(2'd1); chk("R4", got_rd, 8'h90);
        rd(2'd1); chk("R4", got_rd, 8'hB2);

        // R6 / R7: priority and conditional transmit-empty clear
        thr_empty_evt = 1; rx_parity_err = 1; cycle();
        thr_empty_evt = 0; rx_parity_err = 0; rx_data_ready = 1;
        rd(2'd2); chk("R6", got_rd, 8'h06);
        rd(2'd2); chk("R7", got_rd, 8'h06);
        rd(2'd0); chk("R7", got_rd, 8'h02);
        rd(2'd2); chk("R6", got_rd, 8'h04);
        rx_data_ready = 0;
        rd(2'd2); chk("R7", got_rd, 8'h02);
        rd(2'd2); chk("R7", got_rd, 8'h01);

        // R8: disabled sources are hidden but still latched
        wr_ier(4'h0);
        rx_break = 1; thr_empty_evt = 1; cts = 0; cycle();
        rx_break = 0; thr_empty_evt = 0;
        rd(2'd2); chk("R8", got_rd, 8'h01);
        chk("R8", {7'd0, irq}, 8'h00);
        rd(2'd0); chk("R8", got_rd, 8'h08);
        wr_ier(4'h2);
        rd(2'd2); chk("R8", got_rd, 8'h02);

        // Random traffic against the model
        wr_ier(4'hF);
        for (int i = 0; i < 600; i++) begin
            rx_overrun    = ($urandom % 9) == 0;
            rx_parity_err = ($urandom % 9) == 0;
            rx_frame_err  = ($urandom % 9) == 0;
            rx_break      = ($urandom % 11) == 0;
            thr_empty_evt = ($urandom % 7) == 0;
            if (($urandom % 5) == 0) rx_data_ready = ~rx_data_ready;
            if (($urandom % 6) == 0) cts = ~cts;
            if (($urandom % 6) == 0) dsr = ~dsr;
            if (($urandom % 6) == 0) ri  = ~ri;
            if (($urandom % 6) == 0) dcd = ~dcd;
            rd_en  = ($urandom % 2) == 0;
            rd_sel = 2'($urandom % 4);
            ier_wr = ($urandom % 25) == 0;
            ier_wdata = 4'($urandom);
            cycle();
        end
        rd_en = 0; ier_wr = 0;
        finish_run();
    end
endmodule